// File: doc/BRIEF.md
# Fetch-triggered DOS ROM paging controller

This controller decides when a disk-operating-system ROM occupies the lowest 16 KB of a Z80 memory map. It does not act on port writes. It watches opcode fetches (M1 cycles) and the address each fetch comes from. Software chooses the way in and the way out:

- **Entry:** software arms entry, and the next fetch from the ROM's entry page turns the DOS mapping on.
- **Exit:** one of two modes turns it off. In the first, a fetch at or above 0x4000 ends it. In the second, a fetch from any bank mapped to RAM ends it.

A programmable breakpoint on the fetch address raises an NMI request and records whether DOS was active at that moment. Once the CPU acknowledges, an NMI-in-progress flag forces the alternate mapping. A fetch-counted countdown ends that state. When the countdown is spent, the flag drops and the recorded DOS state is put back.

All state lives in flip-flops updated on the rising clock edge and cleared by a synchronous, active-high reset. Control, breakpoint and countdown registers are written through a select-and-strobe port and read back through a combinational mux.

Top module: `dosmap_ctrl`

## Requirements
- R1: After reset, `dos_active`, `nmi_req` and `nmi_busy` are 0, and every register reads back 0.
- R2: While the arm bit (control bit 0) is set, an M1 fetch whose address bits 15:8 equal 0x3D sets `dos_active` at the next edge and clears the arm bit. An M1 fetch from any other page leaves `dos_active` unchanged.
- R3: With arm clear and address-leave (control bit 1) set, an M1 fetch with address bit 15 or bit 14 set clears `dos_active`. A fetch below 0x4000 keeps it.
- R4: With arm clear, address-leave clear and RAM-leave (control bit 2) set, an M1 fetch with `fetch_ram` high clears `dos_active`. A fetch with `fetch_ram` low keeps it.
- R5: With breakpoint-enable (control bit 4) set, an M1 fetch whose address equals the breakpoint register makes `nmi_req` high for exactly one cycle, starting after that edge. There is no pulse if bit 4 is clear, if the address differs, or while an NMI is pending or in progress.
- R6: A raised NMI stays pending until `nmi_ack`. The acknowledge sets `nmi_busy` at the next edge. An `nmi_ack` with nothing pending has no effect.
- R7: The countdown register (select 2) decrements by one on each M1 fetch while it is nonzero. Cycles without M1 leave it unchanged, and at zero it stays at zero.
- R8: An M1 fetch that sees the countdown equal to 1 while `nmi_busy` is set clears `nmi_busy`. If DOS was active when the breakpoint hit, the same edge sets `dos_active` and the arm bit. Otherwise `dos_active` keeps its value.
- R9: A write with `reg_wr` high loads `reg_wdata` into the register picked by `reg_sel`: 0 for control, 1 for breakpoint address, 2 for countdown. `reg_rdata` returns that register in the same cycle, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| m1_valid | input | 1 | Opcode fetch with a valid address this cycle |
| fetch_addr | input | 16 | Fetch address |
| fetch_ram | input | 1 | The fetched bank is mapped to RAM |
| nmi_ack | input | 1 | CPU accepts the pending NMI |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read-back of the selected register |
| dos_active | output | 1 | DOS ROM mapped in the low 16 KB |
| nmi_req | output | 1 | One-cycle NMI request pulse |
| nmi_busy | output | 1 | NMI in progress, alternate mapping forced |

## Verification
**Timing of each result:**
- Every fetch-driven result (`dos_active`, `nmi_req`, `nmi_busy`, the countdown and the arm bit) changes at the rising edge that samples `m1_valid`. It can be seen one cycle after the stimulus.
- `nmi_busy` rises at the edge that samples `nmi_ack`.
- Register read-back is combinational.

**How the checks keep to that timing:**
- Inputs are driven at the falling edge and held across exactly one rising edge.
- Results are sampled at the following falling edge.
- The pulse width of `nmi_req` is confirmed by sampling once more, one edge later.

// File: rtl/dosmap_pkg.sv
package dosmap_pkg;
   localparam int CTRL_W       = 8;
   localparam int CB_ARM       = 0;
   localparam int CB_LEAVE_ADR = 1;
   localparam int CB_LEAVE_RAM = 2;
   localparam int CB_BP_EN     = 4;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_BP   = 2'd1,
      SEL_CNT  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/dosmap_regs.sv
module dosmap_regs
   import dosmap_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   input  logic              m1_valid,
   input  logic              arm_set,
   input  logic              arm_clr,
   output logic              arm,
   output logic              leave_adr,
   output logic              leave_ram,
   output logic              bp_en,
   output logic [ADDR_W-1:0] bp_addr,
   output logic              cnt_expire,
   output logic [ADDR_W-1:0] reg_rdata
);
   localparam int PAD_C = ADDR_W - CTRL_W;
   localparam int PAD_N = ADDR_W - CNT_W;

   logic [CTRL_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              wr_ctrl, wr_bp, wr_cnt;

   assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
   assign wr_bp   = reg_wr && (reg_sel == SEL_BP);
   assign wr_cnt  = reg_wr && (reg_sel == SEL_CNT);

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
         if (arm_clr) ctrl_q[CB_ARM] <= 1'b0;
         if (arm_set) ctrl_q[CB_ARM] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)        bp_addr <= '0;
      else if (wr_bp) bp_addr <= reg_wdata;
   end

   always_ff @(posedge clk) begin
      if (rst)                         cnt_q <= '0;
      else if (wr_cnt)                 cnt_q <= reg_wdata[CNT_W-1:0];
      else if (m1_valid && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign cnt_expire = m1_valid && (cnt_q == CNT_W'(1));
   assign arm        = ctrl_q[CB_ARM];
   assign leave_adr  = ctrl_q[CB_LEAVE_ADR];
   assign leave_ram  = ctrl_q[CB_LEAVE_RAM];
   assign bp_en      = ctrl_q[CB_BP_EN];

   always_comb begin
      case (reg_sel)
         SEL_CTRL: reg_rdata = {{PAD_C{1'b0}}, ctrl_q};
         SEL_BP:   reg_rdata = bp_addr;
         SEL_CNT:  reg_rdata = {{PAD_N{1'b0}}, cnt_q};
         default:  reg_rdata = '0;
      endcase
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      (m1_valid && cnt_q != 0 && !wr_cnt) |=> (cnt_q == $past(cnt_q) - 1'b1)) else $error("countdown step"); // R7
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!m1_valid && !wr_cnt) |=> $stable(cnt_q)) else $error("countdown hold"); // R7
endmodule

// File: rtl/dosmap_page.sv
module dosmap_page #(
   parameter int       ADDR_W  = 16,
   parameter bit [7:0] ENTRY_HI = 8'h3D
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              m1_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_ram,
   input  logic              arm,
   input  logic              leave_adr,
   input  logic              leave_ram,
   input  logic              restore_dos,
   output logic              arm_clr,
   output logic              dos_active
);
   logic entry_hit, above_low;

   assign entry_hit = (fetch_addr[ADDR_W-1 -: 8] == ENTRY_HI);
   assign above_low = (fetch_addr[ADDR_W-1 -: 2] != 2'b00);
   assign arm_clr   = m1_valid && arm && entry_hit && !restore_dos;

   always_ff @(posedge clk) begin
      if (rst) begin
         dos_active <= 1'b0;
      end else if (restore_dos) begin
         dos_active <= 1'b1;
      end else if (m1_valid) begin
         if (arm) begin
            if (entry_hit) dos_active <= 1'b1;
         end else if (leave_adr) begin
            if (above_low) dos_active <= 1'b0;
         end else if (leave_ram) begin
            if (fetch_ram) dos_active <= 1'b0;
         end
      end
   end

   AST_ARM_ENTER: assert property (@(posedge clk) disable iff (rst)
      (m1_valid && arm && entry_hit) |=> dos_active) else $error("entry"); // R2
   AST_ADR_LEAVE: assert property (@(posedge clk) disable iff (rst)
      (m1_valid && !arm && leave_adr && above_low && !restore_dos) |=> !dos_active) else $error("addr leave"); // R3
   AST_RAM_LEAVE: assert property (@(posedge clk) disable iff (rst)
      (m1_valid && !arm && !leave_adr && leave_ram && fetch_ram && !restore_dos) |=> !dos_active) else $error("ram leave"); // R4
endmodule

// File: rtl/dosmap_nmi.sv
module dosmap_nmi #(
   parameter int ADDR_W = 16,
   parameter bit BP_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              m1_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              bp_en,
   input  logic [ADDR_W-1:0] bp_addr,
   input  logic              nmi_ack,
   input  logic              cnt_expire,
   input  logic              dos_active,
   output logic              restore_dos,
   output logic              nmi_req,
   output logic              nmi_busy
);
   logic hit, pending_q, saved_dos_q;

   generate
      if (BP_EN) begin : g_bp
         assign hit = bp_en && m1_valid && (fetch_addr == bp_addr) && !pending_q && !nmi_busy;
      end else begin : g_no_bp
         assign hit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         nmi_req     <= 1'b0;
         pending_q   <= 1'b0;
         saved_dos_q <= 1'b0;
      end else begin
         nmi_req <= hit;
         if (hit)          pending_q <= 1'b1;
         else if (nmi_ack) pending_q <= 1'b0;
         if (hit)          saved_dos_q <= dos_active;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)                       nmi_busy <= 1'b0;
      else if (cnt_expire)           nmi_busy <= 1'b0;
      else if (nmi_ack && pending_q) nmi_busy <= 1'b1;
   end

   assign restore_dos = cnt_expire && nmi_busy && saved_dos_q;

   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
      nmi_req |=> !nmi_req) else $error("req pulse"); // R5
   AST_BUSY_ON_ACK: assert property (@(posedge clk) disable iff (rst)
      $rose(nmi_busy) |-> $past(nmi_ack)) else $error("busy w/o ack"); // R6
   AST_EXPIRE_CLR: assert property (@(posedge clk) disable iff (rst)
      cnt_expire |=> !nmi_busy) else $error("expire"); // R8
endmodule

// File: rtl/dosmap_ctrl.sv
module dosmap_ctrl
   import dosmap_pkg::*;
#(
   parameter int       ADDR_W   = 16,
   parameter int       CNT_W    = 8,
   parameter bit [7:0] ENTRY_HI = 8'h3D,
   parameter bit       BP_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              m1_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_ram,
   input  logic              nmi_ack,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   output logic              dos_active,
   output logic              nmi_req,
   output logic              nmi_busy
);
   generate
      if (ADDR_W <= CTRL_W) begin : g_bad_addr
         $error("ADDR_W must exceed the control width");
      end
      if (CNT_W < 1 || CNT_W > ADDR_W) begin : g_bad_cnt
         $error("CNT_W must be within 1..ADDR_W");
      end
   endgenerate

   logic arm, leave_adr, leave_ram, bp_en, cnt_expire, arm_clr, restore_dos;
   logic [ADDR_W-1:0] bp_addr;

   dosmap_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .m1_valid(m1_valid), .arm_set(restore_dos), .arm_clr(arm_clr),
      .arm(arm), .leave_adr(leave_adr), .leave_ram(leave_ram), .bp_en(bp_en),
      .bp_addr(bp_addr), .cnt_expire(cnt_expire), .reg_rdata(reg_rdata)
   );

   dosmap_page #(.ADDR_W(ADDR_W), .ENTRY_HI(ENTRY_HI)) page_i (
      .clk(clk), .rst(rst), .m1_valid(m1_valid), .fetch_addr(fetch_addr),
      .fetch_ram(fetch_ram), .arm(arm), .leave_adr(leave_adr), .leave_ram(leave_ram),
      .restore_dos(restore_dos), .arm_clr(arm_clr), .dos_active(dos_active)
   );

   dosmap_nmi #(.ADDR_W(ADDR_W), .BP_EN(BP_EN)) nmi_i (
      .clk(clk), .rst(rst), .m1_valid(m1_valid), .fetch_addr(fetch_addr),
      .bp_en(bp_en), .bp_addr(bp_addr), .nmi_ack(nmi_ack), .cnt_expire(cnt_expire),
      .dos_active(dos_active), .restore_dos(restore_dos), .nmi_req(nmi_req),
      .nmi_busy(nmi_busy)
   );

   AST_RESET_IDLE: assert property (@(posedge clk)
      $past(rst) |-> (!dos_active && !nmi_req && !nmi_busy)) else $error("reset state"); // R1
endmodule

// File: tb/dosmap_ctrl_tb_top.sv
module dosmap_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst, m1_valid, fetch_ram, nmi_ack, reg_wr;
   logic [15:0] fetch_addr, reg_wdata, reg_rdata;
   logic [1:0]  reg_sel;
   logic        dos_active, nmi_req, nmi_busy;
   int          checks = 0;
   int          errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dosmap_ctrl dut_i (
      .clk(clk), .rst(rst), .m1_valid(m1_valid), .fetch_addr(fetch_addr),
      .fetch_ram(fetch_ram), .nmi_ack(nmi_ack), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dos_active(dos_active),
      .nmi_req(nmi_req), .nmi_busy(nmi_busy)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] sel, input logic [15:0] d);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_check(input string tag, input logic [1:0] sel, input logic [15:0] exp);
      reg_sel = sel; #1;
      check(tag, reg_rdata, exp);
   endtask

   task automatic fetch(input logic [15:0] a, input logic ram);
      m1_valid = 1'b1; fetch_addr = a; fetch_ram = ram;
      @(posedge clk); @(negedge clk);
      m1_valid = 1'b0;
   endtask

   task automatic idle();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic ack();
      nmi_ack = 1'b1;
      @(posedge clk); @(negedge clk);
      nmi_ack = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 dos", {15'd0, dos_active}, 16'd0);
      check("R1 req", {15'd0, nmi_req}, 16'd0);
      check("R1 busy", {15'd0, nmi_busy}, 16'd0);
      rd_check("R1 ctrl", 2'd0, 16'h0000);
      rd_check("R1 bp", 2'd1, 16'h0000);
      rd_check("R1 cnt", 2'd2, 16'h0000);
   endtask

   task automatic t_regs();
      wr_reg(2'd1, 16'hBEEF);
      rd_check("R9 bp rb", 2'd1, 16'hBEEF);
      wr_reg(2'd2, 16'h0005);
      rd_check("R9 cnt rb", 2'd2, 16'h0005);
      wr_reg(2'd2, 16'h0000);
      wr_reg(2'd0, 16'h0016);
      rd_check("R9 ctrl rb", 2'd0, 16'h0016);
      wr_reg(2'd0, 16'h0000);
   endtask

   task automatic t_arm();
      wr_reg(2'd0, 16'h0001);
      fetch(16'h1234, 1'b0);
      check("R2 other page", {15'd0, dos_active}, 16'd0);
      rd_check("R2 arm held", 2'd0, 16'h0001);
      fetch(16'h3D10, 1'b0);
      check("R2 enter", {15'd0, dos_active}, 16'd1);
      rd_check("R2 arm cleared", 2'd0, 16'h0000);
   endtask

   task automatic t_leave_adr();
      wr_reg(2'd0, 16'h0002);
      fetch(16'h3FFF, 1'b0);
      check("R3 low keeps", {15'd0, dos_active}, 16'd1);
      fetch(16'h8000, 1'b0);
      check("R3 high leaves", {15'd0, dos_active}, 16'd0);
   endtask

   task automatic t_leave_ram();
      wr_reg(2'd0, 16'h0001);
      fetch(16'h3D00, 1'b0);
      wr_reg(2'd0, 16'h0004);
      fetch(16'h5000, 1'b0);
      check("R4 rom keeps", {15'd0, dos_active}, 16'd1);
      fetch(16'h5000, 1'b1);
      check("R4 ram leaves", {15'd0, dos_active}, 16'd0);
   endtask

   task automatic t_bp_plain();
      wr_reg(2'd1, 16'h1234);
      wr_reg(2'd0, 16'h0000);
      fetch(16'h1234, 1'b0);
      check("R5 disabled", {15'd0, nmi_req}, 16'd0);
      wr_reg(2'd0, 16'h0010);
      fetch(16'h1235, 1'b0);
      check("R5 mismatch", {15'd0, nmi_req}, 16'd0);
      ack();
      check("R6 stray ack", {15'd0, nmi_busy}, 16'd0);
      fetch(16'h1234, 1'b0);
      check("R5 pulse", {15'd0, nmi_req}, 16'd1);
      idle();
      check("R5 one cycle", {15'd0, nmi_req}, 16'd0);
      fetch(16'h1234, 1'b0);
      check("R5 no repeat while pending", {15'd0, nmi_req}, 16'd0);
      idle();
      check("R6 pending no busy", {15'd0, nmi_busy}, 16'd0);
      ack();
      check("R6 busy", {15'd0, nmi_busy}, 16'd1);
   endtask

   task automatic t_countdown();
      wr_reg(2'd2, 16'h0003);
      fetch(16'h8000, 1'b0);
      rd_check("R7 dec", 2'd2, 16'h0002);
      idle();
      rd_check("R7 hold", 2'd2, 16'h0002);
      fetch(16'h8001, 1'b0);
      rd_check("R7 dec2", 2'd2, 16'h0001);
      check("R8 busy before", {15'd0, nmi_busy}, 16'd1);
      fetch(16'h8002, 1'b0);
      check("R8 busy cleared", {15'd0, nmi_busy}, 16'd0);
      check("R8 no dos restore", {15'd0, dos_active}, 16'd0);
      rd_check("R7 zero", 2'd2, 16'h0000);
      fetch(16'h8003, 1'b0);
      rd_check("R7 zero stays", 2'd2, 16'h0000);
   endtask

   task automatic t_restore();
      wr_reg(2'd0, 16'h0001);
      fetch(16'h3D00, 1'b0);
      wr_reg(2'd1, 16'h3D05);
      wr_reg(2'd0, 16'h0012);
      fetch(16'h3D05, 1'b0);
      check("R5 hit in dos", {15'd0, nmi_req}, 16'd1);
      ack();
      check("R6 busy2", {15'd0, nmi_busy}, 16'd1);
      wr_reg(2'd2, 16'h0002);
      fetch(16'h8000, 1'b0);
      check("R3 leave during nmi", {15'd0, dos_active}, 16'd0);
      fetch(16'h8002, 1'b0);
      check("R8 dos restored", {15'd0, dos_active}, 16'd1);
      check("R8 busy off", {15'd0, nmi_busy}, 16'd0);
      rd_check("R8 rearmed", 2'd0, 16'h0013);
   endtask

   initial begin
      rst = 1'b1; m1_valid = 1'b0; fetch_addr = '0; fetch_ram = 1'b0;
      nmi_ack = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_regs();
      t_arm();
      t_leave_adr();
      t_leave_ram();
      t_bp_plain();
      t_countdown();
      t_restore();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule